// File: doc/BRIEF.md
# Fractional pixel clock divider

This block derives a pixel clock, and a matching one-cycle period-start strobe, from a stream of input clock enables. The division ratio is a fixed-point number with an 8-bit integer part and a 4-bit fraction, so display timings that do not divide the source evenly still get the right average pixel rate. A phase accumulator advances by one whole step on every selected input tick. It wraps at the programmed ratio and keeps the fractional remainder, so the lengths of successive periods differ by at most one tick.

The high phase of the output is set by two positions counted in half-tick units: a rising position and a falling position. Setting the falling position equal to the integer divisor with the rising position at zero gives a 50% duty cycle. A control register picks one of two tick sources (an internal bus enable or an external enable) and can invert the output.

All registers are written through a simple write port. A three-state controller decides when new values become active:
- **ST_IDLE**: the state after reset. Writes take effect at once. The first tick moves it to ST_RUN.
- **ST_RUN**: the waveform is running. Any register write moves it to ST_PEND.
- **ST_PEND**: new values are held in shadow registers. A tick that ends a period copies them into the active set and returns the controller to ST_RUN. If another write arrives on that same cycle, the controller stays in ST_PEND.

Top module: `pclk_fracdiv`

## Requirements
- R1: After reset, pix_clk and pix_ce are low, the ratio is one (divider value 0x010) and both edge positions are zero. With these values pix_ce pulses on every tick and pix_clk stays low.
- R2: Divider register: address 0, bits 11:0 in sixteenths of a tick. For an integer ratio N (fraction zero), pix_ce pulses exactly once every N ticks.
- R3: For a fractional ratio D/16, each period begins on the first tick at or after a multiple of D/16. Any run of M periods where M·D/16 is a whole number spans exactly M·D/16 ticks.
- R4: An integer field of zero is treated as one, and the fraction is kept. For example, 0x008 acts as 1.5 and 0x000 acts as 1.
- R5: Edge register: address 1, falling position in bits 24:16 and rising position in bits 8:0, both in half-tick units. When rise < fall, pix_clk is high for the ticks whose phase p (in sixteenths) satisfies 8·rise ≤ p < 8·fall.
- R6: When rise > fall, the high window wraps: pix_clk is high when p ≥ 8·rise or p < 8·fall. When the two positions are equal, pix_clk stays at its inactive level.
- R7: Control register: address 2. Bit 0 set selects ext_ce as the tick source, and clear selects int_ce. The source that is not selected has no effect. pix_ce pulses only in the cycle after a tick.
- R8: Control bit 1 inverts pix_clk.
- R9: In ST_IDLE, writes take effect at once. In ST_RUN or ST_PEND, a write takes effect from the first tick after the end of the current period. A write on the very tick that ends a period waits for the following period end.
- R10: On cycles without a tick, pix_clk holds its value, pix_ce is low, and the phase does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_ce | input | 1 | Internal bus clock enable (tick source 0) |
| ext_ce | input | 1 | External clock enable (tick source 1) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 divider, 1 edges, 2 control |
| reg_wdata | input | 32 | Register write data |
| pix_clk | output | 1 | Divided pixel clock level |
| pix_ce | output | 1 | One-cycle strobe at the start of each pixel period |

## Verification
A register write and a period-end tick can land on the same clock edge. At that moment the controller must choose between committing the shadow values and accepting new ones. The bench runs a divide-by-eight waveform and writes a new ratio once mid-period and once exactly on the wrapping tick. It then compares the sample positions of the pix_ce pulses with the positions worked out from R9: the new ratio should appear one period later in the first case and two periods later in the second.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_PEND = 2'd2
    } pclk_state_e;

    localparam logic [1:0] ADDR_DIV  = 2'd0;
    localparam logic [1:0] ADDR_EDGE = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam int FALL_LSB     = 16;
    localparam int CTRL_SEL_BIT = 0;
    localparam int CTRL_INV_BIT = 1;

endpackage

// File: rtl/pclk_regs.sv
module pclk_regs
    import pclk_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4,
    parameter int POS_W  = 9,
    parameter int DATA_W = 32
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    int_ce,
    input  logic                    ext_ce,
    input  logic                    reg_wr,
    input  logic [1:0]              reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    input  logic                    wrap,
    output logic                    tick,
    output pclk_state_e             state,
    output logic [INT_W+FRAC_W-1:0] act_div,
    output logic [POS_W-1:0]        act_rise,
    output logic [POS_W-1:0]        act_fall,
    output logic                    act_sel,
    output logic                    act_inv
);

    localparam int DIV_W = INT_W + FRAC_W;
    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1) << FRAC_W;

    // Integer part of zero becomes one, fraction untouched.
    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] raw);
        logic [DIV_W-1:0] fixed;
        fixed = raw;
        if (raw[DIV_W-1:FRAC_W] == '0) begin
            fixed[FRAC_W] = 1'b1;
        end
        return fixed;
    endfunction

    pclk_state_e state_nxt;

    logic [DIV_W-1:0] sh_div;
    logic [POS_W-1:0] sh_rise;
    logic [POS_W-1:0] sh_fall;
    logic             sh_sel;
    logic             sh_inv;

    logic             wr_div;
    logic             wr_edge;
    logic             wr_ctrl;
    logic             wr_any;
    logic             commit_now;
    logic             direct_load;

    logic [DIV_W-1:0] new_div;
    logic [POS_W-1:0] new_rise;
    logic [POS_W-1:0] new_fall;
    logic             new_sel;
    logic             new_inv;
    logic             wdata_unused;

    assign wdata_unused = ^reg_wdata;

    assign wr_div  = reg_wr && (reg_addr == ADDR_DIV);
    assign wr_edge = reg_wr && (reg_addr == ADDR_EDGE);
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_any  = wr_div || wr_edge || wr_ctrl;

    assign new_div  = clamp_div(reg_wdata[DIV_W-1:0]);
    assign new_rise = reg_wdata[POS_W-1:0];
    assign new_fall = reg_wdata[FALL_LSB +: POS_W];
    assign new_sel  = reg_wdata[CTRL_SEL_BIT];
    assign new_inv  = reg_wdata[CTRL_INV_BIT];

    assign tick = act_sel ? ext_ce : int_ce;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (tick) begin
                    state_nxt = ST_RUN;
                end
            end
            ST_RUN: begin
                if (wr_any) begin
                    state_nxt = ST_PEND;
                end
            end
            ST_PEND: begin
                if (tick && wrap && !wr_any) begin
                    state_nxt = ST_RUN;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Control outputs of the state machine
    always_comb begin
        direct_load = 1'b0;
        commit_now  = 1'b0;
        unique case (state)
            ST_IDLE: direct_load = 1'b1;
            ST_RUN:  commit_now  = 1'b0;
            ST_PEND: commit_now  = tick && wrap;
            default: direct_load = 1'b0;
        endcase
    end

    // Shadow copy: always follows the write port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_div  <= DIV_ONE;
            sh_rise <= '0;
            sh_fall <= '0;
            sh_sel  <= 1'b0;
            sh_inv  <= 1'b0;
        end else begin
            if (wr_div) begin
                sh_div <= new_div;
            end
            if (wr_edge) begin
                sh_rise <= new_rise;
                sh_fall <= new_fall;
            end
            if (wr_ctrl) begin
                sh_sel <= new_sel;
                sh_inv <= new_inv;
            end
        end
    end

    // Active copy: written directly while idle, else at a period end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_div  <= DIV_ONE;
            act_rise <= '0;
            act_fall <= '0;
            act_sel  <= 1'b0;
            act_inv  <= 1'b0;
        end else if (direct_load) begin
            if (wr_div) begin
                act_div <= new_div;
            end
            if (wr_edge) begin
                act_rise <= new_rise;
                act_fall <= new_fall;
            end
            if (wr_ctrl) begin
                act_sel <= new_sel;
                act_inv <= new_inv;
            end
        end else if (commit_now) begin
            act_div  <= sh_div;
            act_rise <= sh_rise;
            act_fall <= sh_fall;
            act_sel  <= sh_sel;
            act_inv  <= sh_inv;
        end
    end

endmodule

// File: rtl/pclk_phase.sv
module pclk_phase #(
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 4
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [DIV_W-1:0] act_div,
    output logic [DIV_W-1:0] phase_q,
    output logic             wrap
);

    localparam int PH_W = DIV_W + 1;
    localparam logic [PH_W-1:0] STEP = PH_W'(1) << FRAC_W;

    logic [PH_W-1:0] sum;
    logic [PH_W-1:0] nxt;

    assign sum  = {1'b0, phase_q} + STEP;
    assign wrap = tick && (sum >= {1'b0, act_div});
    assign nxt  = wrap ? (sum - {1'b0, act_div}) : sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= nxt[DIV_W-1:0];
        end
    end

endmodule

// File: rtl/pclk_wave.sv
module pclk_wave #(
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 4,
    parameter int POS_W  = 9
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [DIV_W-1:0] phase_q,
    input  logic [POS_W-1:0] act_rise,
    input  logic [POS_W-1:0] act_fall,
    input  logic             act_inv,
    output logic             pix_clk,
    output logic             pix_ce
);

    localparam int POS_PH_W = POS_W + FRAC_W - 1;
    localparam int CMP_W    = (POS_PH_W > DIV_W) ? POS_PH_W : DIV_W;
    localparam logic [DIV_W-1:0] STEP_D = DIV_W'(1) << FRAC_W;

    logic [CMP_W-1:0] rise_ph;
    logic [CMP_W-1:0] fall_ph;
    logic [CMP_W-1:0] ph;
    logic             level;

    // Half-tick positions scaled to phase units (sixteenths for FRAC_W=4)
    assign rise_ph = CMP_W'(act_rise) << (FRAC_W - 1);
    assign fall_ph = CMP_W'(act_fall) << (FRAC_W - 1);
    assign ph      = CMP_W'(phase_q);

    always_comb begin
        if (rise_ph < fall_ph) begin
            level = (ph >= rise_ph) && (ph < fall_ph);
        end else if (rise_ph > fall_ph) begin
            level = (ph >= rise_ph) || (ph < fall_ph);
        end else begin
            level = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_clk <= 1'b0;
            pix_ce  <= 1'b0;
        end else if (tick) begin
            pix_clk <= level ^ act_inv;
            pix_ce  <= (phase_q < STEP_D);
        end else begin
            pix_ce  <= 1'b0;
        end
    end

endmodule

// File: rtl/pclk_fracdiv.sv
module pclk_fracdiv
    import pclk_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4,
    parameter int POS_W  = 9,
    parameter int DATA_W = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_ce,
    input  logic              ext_ce,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              pix_clk,
    output logic              pix_ce
);

    localparam int DIV_W = INT_W + FRAC_W;

    pclk_state_e      state;
    logic             tick;
    logic             wrap;
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] act_div;
    logic [POS_W-1:0] act_rise;
    logic [POS_W-1:0] act_fall;
    logic             act_sel;
    logic             act_inv;

    pclk_regs #(
        .INT_W (INT_W),
        .FRAC_W(FRAC_W),
        .POS_W (POS_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_ce   (int_ce),
        .ext_ce   (ext_ce),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .wrap     (wrap),
        .tick     (tick),
        .state    (state),
        .act_div  (act_div),
        .act_rise (act_rise),
        .act_fall (act_fall),
        .act_sel  (act_sel),
        .act_inv  (act_inv)
    );

    pclk_phase #(
        .DIV_W (DIV_W),
        .FRAC_W(FRAC_W)
    ) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .act_div(act_div),
        .phase_q(phase_q),
        .wrap   (wrap)
    );

    pclk_wave #(
        .DIV_W (DIV_W),
        .FRAC_W(FRAC_W),
        .POS_W (POS_W)
    ) u_wave (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .phase_q (phase_q),
        .act_rise(act_rise),
        .act_fall(act_fall),
        .act_inv (act_inv),
        .pix_clk (pix_clk),
        .pix_ce  (pix_ce)
    );

endmodule

module pclk_fracdiv_chk
    import pclk_pkg::*;
#(
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 4
)(
    input logic             clk,
    input logic             rst_n,
    input logic             int_ce,
    input logic             ext_ce,
    input logic             pix_clk,
    input logic             pix_ce,
    input logic [DIV_W-1:0] phase,
    input logic [DIV_W-1:0] act_div,
    input logic             wrap,
    input pclk_state_e      state
);

    // R10
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_ce && !ext_ce) |=> ($stable(pix_clk) && !pix_ce));

    // R7
    strobe_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce |-> $past(int_ce || ext_ce));

    // R2
    phase_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase < act_div);

    // R9
    ratio_frozen_mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !wrap) |=> $stable(act_div));

    // R4
    ratio_int_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_div[DIV_W-1:FRAC_W] != '0);

endmodule

bind pclk_fracdiv pclk_fracdiv_chk #(
    .DIV_W (DIV_W),
    .FRAC_W(FRAC_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .int_ce (int_ce),
    .ext_ce (ext_ce),
    .pix_clk(pix_clk),
    .pix_ce (pix_ce),
    .phase  (phase_q),
    .act_div(act_div),
    .wrap   (wrap),
    .state  (state)
);

// File: tb/pclk_fracdiv_bench.sv
`timescale 1ns/1ps
module pclk_fracdiv_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_ce = 1'b0;
    logic        ext_ce = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        pix_clk;
    logic        pix_ce;

    int n_chk = 0;
    int n_fail = 0;
    int ce_cnt;
    int hi_cnt;
    int ce_pos [0:63];

    always #2.5 clk = ~clk;

    pclk_fracdiv u_pclk_fracdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_ce   (int_ce),
        .ext_ce   (ext_ce),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .pix_clk  (pix_clk),
        .pix_ce   (pix_ce)
    );

    task automatic check(input int act, input int exp, input string req, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        int_ce = 1'b0;
        ext_ce = 1'b0;
        reg_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_reg(input logic [1:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = addr;
        reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [31:0] edges(input int rise, input int fall);
        return (32'(fall) << 16) | 32'(rise);
    endfunction

    // n ticks (int source) or n cycles with an ext tick every third cycle.
    // Optionally writes wr_val to the divider register at cycle wr_at.
    task automatic run(input int n, input bit use_ext, input int wr_at, input logic [31:0] wr_val);
        ce_cnt = 0;
        hi_cnt = 0;
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            if (i >= 1) begin
                if (pix_ce) begin
                    if (ce_cnt < 64) ce_pos[ce_cnt] = i;
                    ce_cnt++;
                end
                if (pix_clk) hi_cnt++;
            end
            if (i < n) begin
                int_ce = 1'b1;
                ext_ce = use_ext && (i % 3 == 0);
            end else begin
                int_ce = 1'b0;
                ext_ce = 1'b0;
            end
            if (i == wr_at) begin
                reg_wr = 1'b1;
                reg_addr = 2'd0;
                reg_wdata = wr_val;
            end else begin
                reg_wr = 1'b0;
            end
        end
        reg_wr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check(int'(pix_clk), 0, "R1", "pix_clk after reset");
        check(int'(pix_ce), 0, "R1", "pix_ce after reset");
        run(8, 0, -1, 0);
        check(ce_cnt, 8, "R1", "strobes at default ratio one");
        check(hi_cnt, 0, "R1", "pix_clk high count with zero edges");
    endtask

    task automatic t_integer();
        do_reset();
        write_reg(2'd0, 32'h040);
        write_reg(2'd1, edges(0, 4));
        run(12, 0, -1, 0);
        check(ce_cnt, 3, "R2", "strobes ratio 4");
        check(hi_cnt, 6, "R5", "high ticks ratio 4 half duty");
        do_reset();
        write_reg(2'd0, 32'h050);
        write_reg(2'd1, edges(0, 5));
        run(15, 0, -1, 0);
        check(ce_cnt, 3, "R2", "strobes ratio 5");
        check(hi_cnt, 9, "R5", "high ticks ratio 5 fall 2.5");
        do_reset();
        write_reg(2'd0, 32'h070);
        write_reg(2'd1, edges(2, 8));
        run(14, 0, -1, 0);
        check(ce_cnt, 2, "R2", "strobes ratio 7");
        check(ce_pos[1] - ce_pos[0], 7, "R2", "strobe spacing ratio 7");
        check(hi_cnt, 6, "R5", "high ticks ratio 7 rise 1 fall 4");
    endtask

    task automatic t_fraction();
        do_reset();
        write_reg(2'd0, 32'h028);
        run(50, 0, -1, 0);
        check(ce_cnt, 20, "R3", "strobes ratio 2.5 over 50 ticks");
        check(ce_pos[2] - ce_pos[0], 5, "R3", "two periods of 2.5");
        do_reset();
        write_reg(2'd0, 32'h034);
        run(52, 0, -1, 0);
        check(ce_cnt, 16, "R3", "strobes ratio 3.25 over 52 ticks");
    endtask

    task automatic t_zero_int();
        do_reset();
        write_reg(2'd0, 32'h008);
        run(6, 0, -1, 0);
        check(ce_cnt, 4, "R4", "zero integer with half fraction acts as 1.5");
        do_reset();
        write_reg(2'd0, 32'h000);
        run(5, 0, -1, 0);
        check(ce_cnt, 5, "R4", "zero ratio acts as one");
    endtask

    task automatic t_wrap_edges();
        do_reset();
        write_reg(2'd0, 32'h080);
        write_reg(2'd1, edges(12, 4));
        run(16, 0, -1, 0);
        check(hi_cnt, 8, "R6", "wrapped window high ticks");
        do_reset();
        write_reg(2'd0, 32'h080);
        write_reg(2'd1, edges(6, 6));
        run(16, 0, -1, 0);
        check(hi_cnt, 0, "R6", "equal edges high ticks");
    endtask

    task automatic t_select();
        do_reset();
        write_reg(2'd0, 32'h020);
        write_reg(2'd1, edges(0, 2));
        write_reg(2'd2, 32'h1);
        run(36, 1, -1, 0);
        check(ce_cnt, 6, "R7", "strobes from ext source only");
        check(hi_cnt, 18, "R7", "high cycles from ext source");
    endtask

    task automatic t_invert();
        do_reset();
        write_reg(2'd0, 32'h050);
        write_reg(2'd1, edges(0, 5));
        write_reg(2'd2, 32'h2);
        run(15, 0, -1, 0);
        check(hi_cnt, 6, "R8", "inverted high ticks ratio 5");
    endtask

    task automatic t_defer();
        do_reset();
        write_reg(2'd0, 32'h080);
        write_reg(2'd1, edges(0, 8));
        run(24, 0, 3, 32'h040);
        check(ce_pos[1], 9, "R9", "period holding mid-period write");
        check(ce_pos[2], 13, "R9", "first period at new ratio");
        check(ce_cnt, 5, "R9", "strobes after deferred update");
        do_reset();
        write_reg(2'd0, 32'h080);
        run(24, 0, 7, 32'h030);
        check(ce_pos[2], 17, "R9", "write on wrap tick waits a period");
        check(ce_pos[3], 20, "R9", "ratio 3 after following boundary");
    endtask

    task automatic t_hold();
        int bad;
        do_reset();
        write_reg(2'd0, 32'h040);
        write_reg(2'd1, edges(0, 4));
        run(2, 0, -1, 0);
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (pix_clk !== 1'b1 || pix_ce !== 1'b0) bad++;
        end
        check(bad, 0, "R10", "cycles where outputs moved without ticks");
        run(2, 0, -1, 0);
        check(ce_cnt, 0, "R10", "phase held: no new period start");
        check(hi_cnt, 0, "R10", "phase held: low half follows");
    endtask

    initial begin
        t_reset();
        t_integer();
        t_fraction();
        t_zero_int();
        t_wrap_edges();
        t_select();
        t_invert();
        t_defer();
        t_hold();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule